// File: doc/BRIEF.md
# M-Scan Pixel Address Generator

This block produces the pixel fetch order for a tiled two-dimensional wavelet pipeline that reuses each column's filter state for N consecutive cycles. The image is divided into horizontal strips 2N rows tall. In every cycle the generator names two vertically adjacent pixels: a row address pair and one column address. It walks down the strip inside one column for N cycles, two rows at a time. It then steps one column right, and after the last column it drops to the next strip. The resulting path looks like a chain of M shapes. The column transform can therefore hand its outputs to the row transform at once, with no large intermediate store.

A start pulse, taken only when the generator is idle, captures the image width and height given on the inputs. A stall input stops all progress and holds every output. A pair counts as consumed in each cycle where valid is high and stall is low. A start-of-period flag marks the first cycle spent in each column. An end-of-strip flag marks the last cycle of a strip. A one-cycle done pulse follows the last pair. The default build has N = 2, which gives strips four rows tall, and it supports widths such as 128 pixels.

The controller has three states. ST_IDLE waits for start. ST_SCAN emits pairs. ST_FINISH raises done for one cycle. The transitions are as follows:
- ST_IDLE goes to ST_SCAN on start when the captured dimensions hold at least one full strip.
- ST_IDLE goes to ST_FINISH on start when they do not.
- ST_SCAN goes to ST_FINISH when the final pair is consumed.
- ST_FINISH always returns to ST_IDLE.

Top module: `mscan_gen`

## Requirements
- R1: After reset, valid, done, sop and eos are all low, and they stay low until a start is accepted.
- R2: When start is accepted in idle with img_w >= 1 and img_h >= 2N, valid rises in the next cycle with row0 = 0, row1 = 1 and col = 0.
- R3: In every valid cycle row1 = row0 + 1. In the k-th cycle spent in a column (k = 0..N-1) of strip s, row0 = s*2N + 2k.
- R4: The column address holds for N consumed pairs and then increments. After column img_w-1 the scan moves to column 0 of the next strip.
- R5: sop is high in exactly the valid cycles where k = 0.
- R6: eos is high in exactly the valid cycles where col = img_w-1 and k = N-1.
- R7: While valid is high and stall is high, no pair is consumed, and in the next cycle valid, row0, row1, col, sop and eos are unchanged.
- R8: The scan covers floor(img_h/2N) strips, so rows below the last full strip are never named. In the cycle after the final pair is consumed, done is high and valid is low. In the cycle after that, done is low again.
- R9: A start accepted with img_w = 0 or img_h < 2N produces no valid cycle. In that case done is high in the cycle right after start.
- R10: start, img_w and img_h have no effect except in the idle cycle that accepts a start. A running scan keeps the dimensions it captured at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (idle only) |
| stall | input | 1 | Freeze progress and hold outputs |
| img_w | input | COLW | Image width in pixels |
| img_h | input | ROWW | Image height in pixels |
| valid | output | 1 | A pixel pair is being named |
| row0 | output | ROWW | Upper row of the pair |
| row1 | output | ROWW | Lower row of the pair |
| col | output | COLW | Column of the pair |
| sop | output | 1 | First cycle in the current column |
| eos | output | 1 | Last cycle of the current strip |
| done | output | 1 | One-cycle pulse after the final pair |

## Verification
Two functions can fall in the same cycle: a stall and the end-of-strip cycle, including the very last pair of the image. If they clash, eos could be dropped, or done could arrive early. One scenario raises stall for two cycles each time the expected pair carries eos. The bench then checks every cycle: eos and the addresses must hold through the stall, the next strip must begin only after release, and done must appear exactly one cycle after the delayed final pair.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } mscan_state_e;
endpackage

// File: rtl/mscan_wrap.sv
// Counter that clears on request and wraps to zero after reaching a limit.
module mscan_wrap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         at_end
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    assign at_end = (cnt_q == lim);
    assign cnt    = cnt_q;
endmodule

// File: rtl/mscan_rowaddr.sv
// Row pair from strip index and phase within the column.
module mscan_rowaddr #(
    parameter int N    = 2,
    parameter int ROWW = 8,
    parameter int PHW  = 1
) (
    input  logic [ROWW-1:0] strip,
    input  logic [PHW-1:0]  phase,
    output logic [ROWW-1:0] row0,
    output logic [ROWW-1:0] row1
);
    localparam int SH      = 2 * N;
    localparam bit SH_POW2 = ((SH & (SH - 1)) == 0);
    localparam int SH_LOG  = $clog2(SH);

    logic [ROWW-1:0] base;
    logic [ROWW-1:0] offs;

    generate
        if (SH_POW2) begin : g_shift
            assign base = strip << SH_LOG;
        end else begin : g_mult
            assign base = strip * ROWW'(SH);
        end
    endgenerate

    assign offs = ROWW'({phase, 1'b0});
    assign row0 = base + offs;
    assign row1 = {base[ROWW-1:1] + offs[ROWW-1:1], 1'b1};
endmodule

// File: rtl/mscan_fsm.sv
module mscan_fsm
    import mscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dims_ok,
    input  logic final_step,
    output logic load,
    output logic valid,
    output logic done
);
    mscan_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = dims_ok ? ST_SCAN : ST_FINISH;
                end
            end
            ST_SCAN: begin
                if (final_step) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load  = 1'b0;
        valid = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE:   load  = start;
            ST_SCAN:   valid = 1'b1;
            ST_FINISH: done  = 1'b1;
            default: begin
                load = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mscan_gen.sv
module mscan_gen #(
    parameter int N    = 2,
    parameter int COLW = 8,
    parameter int ROWW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stall,
    input  logic [COLW-1:0] img_w,
    input  logic [ROWW-1:0] img_h,
    output logic            valid,
    output logic [ROWW-1:0] row0,
    output logic [ROWW-1:0] row1,
    output logic [COLW-1:0] col,
    output logic            sop,
    output logic            eos,
    output logic            done
);
    localparam int SH  = 2 * N;
    localparam int PHW = (N > 1) ? $clog2(N) : 1;

    logic            load;
    logic            dims_ok;
    logic            step;
    logic            final_step;
    logic [COLW-1:0] w_q;
    logic [ROWW-1:0] ns_q;
    logic [ROWW-1:0] ns_in;
    logic [PHW-1:0]  phase;
    logic [ROWW-1:0] strip;
    logic            ph_end, col_end, st_end;

    assign ns_in   = img_h / ROWW'(SH);
    assign dims_ok = (img_w != '0) && (ns_in != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q  <= '0;
            ns_q <= '0;
        end else if (load) begin
            w_q  <= img_w;
            ns_q <= ns_in;
        end
    end

    assign step       = valid && !stall;
    assign final_step = step && ph_end && col_end && st_end;

    mscan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dims_ok    (dims_ok),
        .final_step (final_step),
        .load       (load),
        .valid      (valid),
        .done       (done)
    );

    mscan_wrap #(.W(PHW)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (load),
        .adv    (step),
        .lim    (PHW'(N - 1)),
        .cnt    (phase),
        .at_end (ph_end)
    );

    mscan_wrap #(.W(COLW)) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (load),
        .adv    (step && ph_end),
        .lim    (w_q - 1'b1),
        .cnt    (col),
        .at_end (col_end)
    );

    mscan_wrap #(.W(ROWW)) u_strip (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (load),
        .adv    (step && ph_end && col_end),
        .lim    (ns_q - 1'b1),
        .cnt    (strip),
        .at_end (st_end)
    );

    mscan_rowaddr #(.N(N), .ROWW(ROWW), .PHW(PHW)) u_rows (
        .strip (strip),
        .phase (phase),
        .row0  (row0),
        .row1  (row1)
    );

    assign sop = valid && (phase == '0);
    assign eos = valid && ph_end && col_end;
endmodule

// File: rtl/mscan_gen_chk.sv
module mscan_gen_chk #(
    parameter int COLW = 8,
    parameter int ROWW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic            valid,
    input logic [ROWW-1:0] row0,
    input logic [ROWW-1:0] row1,
    input logic [COLW-1:0] col,
    input logic            sop,
    input logic            eos,
    input logic            done
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && stall) |=> (valid && $stable(row0) && $stable(row1) && $stable(col) && $stable(sop) && $stable(eos))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid); // R8

    AST_EOS_WRAP_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !stall && eos) |=> (col == '0)); // R4

    AST_NEW_COL_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid) && !$past(stall) && (col != $past(col))) |-> sop); // R5

    AST_PAIR_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (row1 == row0 + 1'b1)); // R3
endmodule

bind mscan_gen mscan_gen_chk #(.COLW(COLW), .ROWW(ROWW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (stall),
    .valid (valid),
    .row0  (row0),
    .row1  (row1),
    .col   (col),
    .sop   (sop),
    .eos   (eos),
    .done  (done)
);

// File: tb/tb_mscan_gen.sv
`timescale 1ns/1ps
module tb_mscan_gen;
    localparam int N    = 2;
    localparam int COLW = 8;
    localparam int ROWW = 8;
    localparam int SH   = 2 * N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            stall = 1'b0;
    logic [COLW-1:0] img_w = '0;
    logic [ROWW-1:0] img_h = '0;
    logic            valid;
    logic [ROWW-1:0] row0, row1;
    logic [COLW-1:0] col;
    logic            sop, eos, done;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    mscan_gen #(.N(N), .COLW(COLW), .ROWW(ROWW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
        .img_w(img_w), .img_h(img_h), .valid(valid), .row0(row0),
        .row1(row1), .col(col), .sop(sop), .eos(eos), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(valid == 1'b0, "R1 valid", int'(valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(sop == 1'b0, "R1 sop", int'(sop), 0);
        chk(eos == 1'b0, "R1 eos", int'(eos), 0);
    endtask

    // mode 0: no stall, 1: stall every third cycle, 2: two-cycle stall on each eos
    task automatic run_scan(input int w, input int h, input int mode, input int poke);
        int es = 0, ec = 0, ek = 0, ns, cyc = 0, hold = 0;
        bit scanning = 1'b1;
        bit st, e_eos;
        ns = h / SH;
        @(negedge clk);
        img_w = COLW'(w);
        img_h = ROWW'(h);
        start = 1'b1;
        stall = 1'b0;
        while (scanning) begin
            @(negedge clk);
            start = 1'b0;
            e_eos = (ec == w - 1) && (ek == N - 1);
            if (cyc == 0) begin
                chk(row0 == 0 && col == 0, "R2 first pair", int'(row0) + int'(col), 0);
            end
            chk(valid == 1'b1, "R2/R4 valid", int'(valid), 1);
            chk(int'(row0) == es * SH + 2 * ek, "R3 row0", int'(row0), es * SH + 2 * ek);
            chk(int'(row1) == es * SH + 2 * ek + 1, "R3 row1", int'(row1), es * SH + 2 * ek + 1);
            chk(int'(col) == ec, "R4 col", int'(col), ec);
            chk(sop == (ek == 0), "R5 sop", int'(sop), int'(ek == 0));
            chk(eos == e_eos, "R6 eos", int'(eos), int'(e_eos));
            chk(done == 1'b0, "R8 early done", int'(done), 0);
            case (mode)
                1:       st = (cyc % 3 == 1);
                2:       st = e_eos && (hold < 2);
                default: st = 1'b0;
            endcase
            stall = st;
            if (cyc == poke) begin
                start = 1'b1;
                img_w = COLW'(w + 3);
                img_h = ROWW'(h + 8);
            end
            if (st) begin
                hold++;
            end else begin
                hold = 0;
                if (ek == N - 1) begin
                    ek = 0;
                    if (ec == w - 1) begin
                        ec = 0;
                        if (es == ns - 1) scanning = 1'b0;
                        else es++;
                    end else begin
                        ec++;
                    end
                end else begin
                    ek++;
                end
            end
            cyc++;
        end
        @(negedge clk);
        start = 1'b0;
        stall = 1'b0;
        chk(done == 1'b1, "R8 done after final", int'(done), 1);
        chk(valid == 1'b0, "R8 valid at done", int'(valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single", int'(done), 0);
        chk(valid == 1'b0, "R8 idle after done", int'(valid), 0);
    endtask

    task automatic run_empty(input int w, input int h);
        @(negedge clk);
        img_w = COLW'(w);
        img_h = ROWW'(h);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(valid == 1'b0, "R9 no pair", int'(valid), 0);
        chk(done == 1'b1, "R9 done", int'(done), 1);
        @(negedge clk);
        chk(valid == 1'b0 && done == 1'b0, "R9 back idle", int'(valid) + int'(done), 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) t_reset();
        run_scan(3, 4, 0, -1);      // R2 R3 R4 single strip
        run_scan(5, 8, 1, -1);      // R7 periodic stall
        run_scan(128, 8, 0, -1);    // R4 wide image
        run_scan(4, 10, 2, -1);     // R6 R7 R8 stall on eos, partial rows dropped
        run_scan(6, 8, 0, 5);       // R10 start and dims changed mid-scan
        run_empty(0, 8);            // R9 zero width
        run_empty(5, 3);            // R9 short height
        run_scan(2, 4, 0, -1);      // R2 restart after empty runs
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule